// File: doc/BRIEF.md
# Power-Management Register Window

This block is a relocatable window of 128 byte addresses that holds a system's power-management state. Within it sit the 16-bit event status, event enable and control registers, a free-running timer, a 16-byte general-purpose event array (8 status bytes followed by 8 enable bytes) and a 32-bit register of enables for management interrupts. A configuration write places the window on any 128-byte boundary. A base of zero removes it from the address map. A firmware or driver agent reaches the registers through a simple bus with an address, an access size, write data and read data. Hardware events set status bits.

The block drives one level-sensitive interrupt line, `sci`. It is high while any of four event sources is both pending and enabled: the timer, the global lock, the power button and the real-time-clock alarm. Accesses whose width has no matching register at the target offset are split into narrower accesses. A 32-bit access becomes two 16-bit halves, and a 16-bit access becomes two bytes. The lowest part goes first, so the pieces land on the lanes where a wide register would have put them.

Top module: `pm_regblock`

## Requirements
- R1: `cfg_base` gives the window base in 128-byte units and is loaded when `cfg_base_we` is high. An access hits when `bus_req` is high, the base is non-zero and `bus_addr[15:7]` equals the base. With base zero, no access hits: reads return 0 and writes change nothing. Reset sets the base to zero.
- R2: The status register at offset 0x00 has four event bits: bit 0 timer, bit 5 global lock (`glk_evt`), bit 8 power button (`pwrbtn_evt` or `pwrdown_req`) and bit 10 alarm (`rtc_evt`). Its other bits read 0. Writing 1 to a bit clears it and writing 0 leaves it unchanged. An event in the same cycle as a clear leaves the bit set.
- R3: The enable register at 0x02 and the control register at 0x04 are 16-bit read/write.
- R4: `sci` is high exactly when (status AND enable AND 0x0521) is non-zero, one cycle after the write or event that changed either register. General-purpose events never affect `sci`.
- R5: The timer is a 24-bit counter that increments every clock and resets to 0. A 32-bit read at 0x08 returns it zero-extended. Writes to 0x08 are ignored.
- R6: When the timer's most significant bit toggles, status bit 0 is set, but only if enable bit 0 is set at that time.
- R7: Offsets 0x20–0x27 hold general-purpose status and 0x28–0x2F hold general-purpose enable, accessed per byte. `gpe_evt[n]` sets bit n%8 of status byte n/8. Status bits are write-one-to-clear and enable bytes are read/write.
- R8: A 32-bit register at 0x30 is read/write.
- R9: Sizes are coded 0 byte, 1 half-word and 2 word. A word access at an offset with no 32-bit register becomes two half-word accesses at offset and offset+2, on lanes 0–1 and 2–3. A half-word access at an offset with no 16-bit register becomes two byte accesses at offset and offset+1. Bytes outside 0x20–0x2F read 0 and ignore writes, including byte accesses to the 16-bit registers.
- R10: Unimplemented offsets read 0 and ignore writes. Size code 3 performs no access and reads 0.
- R11: Reset clears the status, enable, control, timer, general-purpose and 32-bit enable registers, and `sci` is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base_we | input | 1 | Load the window base |
| cfg_base | input | 9 | Window base in 128-byte units; 0 unmaps |
| bus_req | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 16 | Byte address |
| bus_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 none |
| bus_wdata | input | 32 | Write data, lane 0 at bits 7:0 |
| bus_rdata | output | 32 | Read data, valid in the same cycle |
| pwrbtn_evt | input | 1 | Power-button event pulse |
| rtc_evt | input | 1 | Alarm event pulse |
| glk_evt | input | 1 | Global-lock event pulse |
| pwrdown_req | input | 1 | Power-down request, sets the power-button status |
| gpe_evt | input | 64 | General-purpose event pulses |
| sci | output | 1 | Level interrupt |

## Verification
The hardest state to reach from the ports is the timer-status arming. Its most significant bit toggles only once every 2^23 clocks at the default width. The bench therefore builds the block with a 10-bit timer and waits across two toggles, first with the timer enable clear and then with it set. Before that, a table of reads and writes reaches the splitting cases: word accesses that span a 16-bit pair or four general-purpose bytes, byte accesses that hit 16-bit registers, and writes to the read-only timer offset. Directed sequences then cover an event arriving in the same cycle as its clear, relocation and unmapping of the window, and a reset in the middle of the run.

// File: rtl/pm_regblock_pkg.sv
package pm_regblock_pkg;

    localparam int WIN_BITS   = 7;
    localparam int GPE_BYTES  = 8;
    localparam int GPE_REGS   = 2 * GPE_BYTES;
    localparam int GPE_BITS   = 8 * GPE_BYTES;

    localparam logic [6:0] OFS_STS = 7'h00;
    localparam logic [6:0] OFS_EN  = 7'h02;
    localparam logic [6:0] OFS_CTL = 7'h04;
    localparam logic [6:0] OFS_TMR = 7'h08;
    localparam logic [6:0] OFS_GPE = 7'h20;
    localparam logic [6:0] OFS_SMI = 7'h30;

    localparam int BIT_TMR = 0;
    localparam int BIT_GLK = 5;
    localparam int BIT_PWR = 8;
    localparam int BIT_RTC = 10;

    localparam logic [15:0] STS_IMPL = 16'h0521;
    localparam logic [15:0] SCI_MASK = 16'h0521;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_NONE = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        LF_NONE = 3'd0,
        LF_ZERO = 3'd1,
        LF_STS  = 3'd2,
        LF_EN   = 3'd3,
        LF_CTL  = 3'd4,
        LF_TMR  = 3'd5,
        LF_SMI  = 3'd6,
        LF_GPE  = 3'd7
    } leaf_kind_e;

    typedef struct packed {
        leaf_kind_e kind;
        logic [3:0] gidx;
    } leaf_t;

    function automatic leaf_t byte_leaf(input logic [6:0] o);
        leaf_t r;
        r.kind = LF_ZERO;
        r.gidx = o[3:0];
        if (o[6:4] == OFS_GPE[6:4])
            r.kind = LF_GPE;
        return r;
    endfunction

    function automatic leaf_t [1:0] half_pair(input logic [6:0] o);
        leaf_t [1:0] r;
        r = '0;
        if (o == OFS_STS)      r[0].kind = LF_STS;
        else if (o == OFS_EN)  r[0].kind = LF_EN;
        else if (o == OFS_CTL) r[0].kind = LF_CTL;
        else begin
            r[0] = byte_leaf(o);
            r[1] = byte_leaf(o + 7'd1);
        end
        return r;
    endfunction

endpackage

// File: rtl/pm_access_split.sv
module pm_access_split
    import pm_regblock_pkg::*;
(
    input  logic [6:0]       off,
    input  logic [1:0]       size,
    input  logic             is_wr,
    output leaf_t [3:0]      slot
);
    always_comb begin
        slot = '0;
        case (acc_size_e'(size))
            SZ_BYTE: slot[0] = byte_leaf(off);
            SZ_HALF: slot[1:0] = half_pair(off);
            SZ_WORD: begin
                if (off == OFS_SMI)
                    slot[0].kind = LF_SMI;
                else if (off == OFS_TMR && !is_wr)
                    slot[0].kind = LF_TMR;
                else begin
                    slot[1:0] = half_pair(off);
                    slot[3:2] = half_pair(off + 7'd2);
                end
            end
            default: slot = '0;
        endcase
    end
endmodule

// File: rtl/pm_timer.sv
module pm_timer #(
    parameter int TMR_BITS = 24
) (
    input  logic                clk,
    input  logic                rst,
    output logic [TMR_BITS-1:0] count,
    output logic                msb_flip
);
    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + 1'b1;
    end

    // the next increment carries into the top bit
    assign msb_flip = &count[TMR_BITS-2:0];
endmodule

// File: rtl/pm_gpe_bank.sv
module pm_gpe_bank
    import pm_regblock_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [GPE_BITS-1:0]   evt,
    input  logic [GPE_REGS-1:0]   we,
    input  logic [GPE_REGS*8-1:0] wd,
    output logic [GPE_BITS-1:0]   sts,
    output logic [GPE_BITS-1:0]   en
);
    for (genvar b = 0; b < GPE_BYTES; b++) begin : g_byte
        logic [7:0] clr;
        assign clr = we[b] ? wd[b*8 +: 8] : 8'h00;

        always_ff @(posedge clk) begin
            if (rst) begin
                sts[b*8 +: 8] <= '0;
                en[b*8 +: 8]  <= '0;
            end else begin
                sts[b*8 +: 8] <= (sts[b*8 +: 8] & ~clr) | evt[b*8 +: 8];
                if (we[GPE_BYTES + b])
                    en[b*8 +: 8] <= wd[(GPE_BYTES + b)*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/pm_regblock.sv
module pm_regblock
    import pm_regblock_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int TMR_BITS = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_base_we,
    input  logic [ADDR_W-8:0]       cfg_base,
    input  logic                    bus_req,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [1:0]              bus_size,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    input  logic                    pwrbtn_evt,
    input  logic                    rtc_evt,
    input  logic                    glk_evt,
    input  logic                    pwrdown_req,
    input  logic [GPE_BITS-1:0]     gpe_evt,
    output logic                    sci
);
    localparam int BASE_W = ADDR_W - WIN_BITS;

    logic [BASE_W-1:0]   base_hi;
    logic                hit;
    logic                wr_hit;
    leaf_t [3:0]         slot;

    logic [15:0]         pm1_sts, pm1_en, pm1_ctl;
    logic [31:0]         smi_en;
    logic [TMR_BITS-1:0] tmr_count;
    logic                tmr_flip;
    logic [GPE_BITS-1:0] gpe_sts, gpe_en;

    logic                sts_we, en_we, ctl_we, smi_we;
    logic [15:0]         sts_wd, en_wd, ctl_wd;
    logic [31:0]         smi_wd;
    logic [GPE_REGS-1:0] gpe_we;
    logic [GPE_REGS*8-1:0] gpe_wd;
    logic [15:0]         sts_set;
    logic [15:0]         sts_clr;

    // window placement
    always_ff @(posedge clk) begin
        if (rst)              base_hi <= '0;
        else if (cfg_base_we) base_hi <= cfg_base;
    end

    assign hit    = bus_req && (base_hi != '0) && (bus_addr[ADDR_W-1:WIN_BITS] == base_hi);
    assign wr_hit = hit && bus_wr;

    pm_access_split u_split (
        .off   (bus_addr[WIN_BITS-1:0]),
        .size  (bus_size),
        .is_wr (bus_wr),
        .slot  (slot)
    );

    pm_timer #(.TMR_BITS(TMR_BITS)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .count    (tmr_count),
        .msb_flip (tmr_flip)
    );

    pm_gpe_bank u_gpe (
        .clk (clk),
        .rst (rst),
        .evt (gpe_evt),
        .we  (gpe_we),
        .wd  (gpe_wd),
        .sts (gpe_sts),
        .en  (gpe_en)
    );

    // write steering: each lane's leaf picks its target
    always_comb begin
        logic [31:0] sh;
        sts_we = 1'b0; en_we = 1'b0; ctl_we = 1'b0; smi_we = 1'b0;
        sts_wd = '0;   en_wd = '0;   ctl_wd = '0;   smi_wd = '0;
        gpe_we = '0;   gpe_wd = '0;
        for (int l = 0; l < 4; l++) begin
            sh = bus_wdata >> (8 * l);
            if (wr_hit) begin
                case (slot[l].kind)
                    LF_STS: begin sts_we = 1'b1; sts_wd = sh[15:0]; end
                    LF_EN:  begin en_we  = 1'b1; en_wd  = sh[15:0]; end
                    LF_CTL: begin ctl_we = 1'b1; ctl_wd = sh[15:0]; end
                    LF_SMI: begin smi_we = 1'b1; smi_wd = sh;       end
                    LF_GPE: begin
                        gpe_we[slot[l].gidx]          = 1'b1;
                        gpe_wd[slot[l].gidx*8 +: 8]   = sh[7:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    // read assembly
    always_comb begin
        logic [7:0] gb;
        bus_rdata = '0;
        for (int l = 0; l < 4; l++) begin
            gb = slot[l].gidx[3] ? gpe_en[slot[l].gidx[2:0]*8 +: 8]
                                 : gpe_sts[slot[l].gidx[2:0]*8 +: 8];
            if (hit && !bus_wr) begin
                case (slot[l].kind)
                    LF_STS: bus_rdata = bus_rdata | (32'(pm1_sts) << (8 * l));
                    LF_EN:  bus_rdata = bus_rdata | (32'(pm1_en)  << (8 * l));
                    LF_CTL: bus_rdata = bus_rdata | (32'(pm1_ctl) << (8 * l));
                    LF_TMR: bus_rdata = bus_rdata | 32'(tmr_count);
                    LF_SMI: bus_rdata = bus_rdata | smi_en;
                    LF_GPE: bus_rdata = bus_rdata | (32'(gb) << (8 * l));
                    default: ;
                endcase
            end
        end
    end

    // event status: sets win over clears
    always_comb begin
        sts_set          = '0;
        sts_set[BIT_TMR] = tmr_flip && pm1_en[BIT_TMR];
        sts_set[BIT_GLK] = glk_evt;
        sts_set[BIT_PWR] = pwrbtn_evt || pwrdown_req;
        sts_set[BIT_RTC] = rtc_evt;
        sts_clr          = sts_we ? sts_wd : 16'h0000;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pm1_sts <= '0;
            pm1_en  <= '0;
            pm1_ctl <= '0;
            smi_en  <= '0;
        end else begin
            pm1_sts <= ((pm1_sts & ~sts_clr) | sts_set) & STS_IMPL;
            if (en_we)  pm1_en  <= en_wd;
            if (ctl_we) pm1_ctl <= ctl_wd;
            if (smi_we) smi_en  <= smi_wd;
        end
    end

    assign sci = |(pm1_sts & pm1_en & SCI_MASK);

endmodule

// File: rtl/pm_regblock_chk.sv
module pm_regblock_chk
    import pm_regblock_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int TMR_BITS = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_base_we,
    input logic [ADDR_W-8:0] cfg_base,
    input logic              hit,
    input logic              bus_wr,
    input logic [1:0]        bus_size,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              pwrbtn_evt,
    input logic              pwrdown_req,
    input logic              glk_evt,
    input logic              tmr_flip,
    input logic [15:0]       pm1_sts,
    input logic [15:0]       pm1_en,
    input logic [ADDR_W-8:0] base_hi,
    input logic              sci
);
    // R1
    unmap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_base_we && cfg_base == '0) |=> (bus_rdata == 32'h0));

    // R2
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && bus_wr && bus_size == 2'd1 && bus_addr[6:0] == 7'h00
         && bus_wdata[BIT_GLK] && !glk_evt) |=> !pm1_sts[BIT_GLK]);

    // R2
    pwr_set_chk: assert property (@(posedge clk) disable iff (rst)
        (pwrbtn_evt || pwrdown_req) |=> pm1_sts[BIT_PWR]);

    // R4
    sci_off_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && bus_wr && bus_size == 2'd1 && bus_addr[6:0] == 7'h02
         && bus_wdata[15:0] == 16'h0) |=> !sci);

    // R6
    tmr_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (tmr_flip && pm1_en[BIT_TMR]) |=> pm1_sts[BIT_TMR]);

    // R6
    tmr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tmr_flip && !pm1_en[BIT_TMR] && !pm1_sts[BIT_TMR]) |=> !pm1_sts[BIT_TMR]);

    // R11
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (base_hi == '0 && pm1_sts == 16'h0 && !sci));
endmodule

bind pm_regblock pm_regblock_chk #(.ADDR_W(ADDR_W), .TMR_BITS(TMR_BITS)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .cfg_base_we (cfg_base_we),
    .cfg_base    (cfg_base),
    .hit         (hit),
    .bus_wr      (bus_wr),
    .bus_size    (bus_size),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pwrbtn_evt  (pwrbtn_evt),
    .pwrdown_req (pwrdown_req),
    .glk_evt     (glk_evt),
    .tmr_flip    (tmr_flip),
    .pm1_sts     (pm1_sts),
    .pm1_en      (pm1_en),
    .base_hi     (base_hi),
    .sci         (sci)
);

// File: tb/pm_regblock_test.sv
module pm_regblock_test;
    localparam int TB_TMR = 10;
    localparam logic [31:0] TMASK = (32'h1 << TB_TMR) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_base_we = 1'b0;
    logic [8:0]  cfg_base = '0;
    logic        bus_req = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwrbtn_evt = 1'b0, rtc_evt = 1'b0, glk_evt = 1'b0, pwrdown_req = 1'b0;
    logic [63:0] gpe_evt = '0;
    logic        sci;

    int n_run = 0;
    int n_fail = 0;
    logic [15:0] win = 16'h0400;

    always #5 clk = ~clk;

    pm_regblock #(.ADDR_W(16), .TMR_BITS(TB_TMR)) uut (
        .clk(clk), .rst(rst), .cfg_base_we(cfg_base_we), .cfg_base(cfg_base),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwrbtn_evt(pwrbtn_evt),
        .rtc_evt(rtc_evt), .glk_evt(glk_evt), .pwrdown_req(pwrdown_req),
        .gpe_evt(gpe_evt), .sci(sci)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [6:0]  off;
        logic [31:0] wd;
        logic [31:0] ex;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd1, 7'h02, 32'h0000_0520, 32'h0, 4'd3},  // R3 enable write
        '{1'b0, 2'd1, 7'h02, 32'h0,         32'h0000_0520, 4'd3},
        '{1'b1, 2'd1, 7'h04, 32'h0000_BEEF, 32'h0, 4'd3},  // R3 control
        '{1'b0, 2'd1, 7'h04, 32'h0,         32'h0000_BEEF, 4'd3},
        '{1'b1, 2'd2, 7'h30, 32'hDEAD_BEEF, 32'h0, 4'd8},  // R8
        '{1'b0, 2'd2, 7'h30, 32'h0,         32'hDEAD_BEEF, 4'd8},
        '{1'b1, 2'd2, 7'h28, 32'h4433_2211, 32'h0, 4'd9},  // R9 word -> bytes, R7
        '{1'b0, 2'd2, 7'h28, 32'h0,         32'h4433_2211, 4'd7},
        '{1'b1, 2'd0, 7'h2F, 32'h0000_0099, 32'h0, 4'd7},
        '{1'b0, 2'd2, 7'h2C, 32'h0,         32'h9900_0000, 4'd9},
        '{1'b0, 2'd2, 7'h00, 32'h0,         32'h0520_0000, 4'd9},  // R9 word -> two halves
        '{1'b0, 2'd0, 7'h00, 32'h0,         32'h0, 4'd9},  // R9 byte on 16-bit reg
        '{1'b1, 2'd0, 7'h02, 32'h0000_00FF, 32'h0, 4'd9},
        '{1'b0, 2'd1, 7'h02, 32'h0,         32'h0000_0520, 4'd9},
        '{1'b1, 2'd2, 7'h08, 32'hFFFF_FFFF, 32'h0, 4'd5},  // R5 write ignored
        '{1'b0, 2'd1, 7'h08, 32'h0,         32'h0, 4'd9},
        '{1'b0, 2'd2, 7'h04, 32'h0,         32'h0000_BEEF, 4'd9},
        '{1'b0, 2'd2, 7'h40, 32'h0,         32'h0, 4'd10}, // R10
        '{1'b1, 2'd1, 7'h40, 32'h0000_1234, 32'h0, 4'd10},
        '{1'b0, 2'd1, 7'h40, 32'h0,         32'h0, 4'd10},
        '{1'b1, 2'd3, 7'h30, 32'h0,         32'h0, 4'd10}, // R10 size 3
        '{1'b0, 2'd2, 7'h30, 32'h0,         32'hDEAD_BEEF, 4'd10},
        '{1'b0, 2'd3, 7'h30, 32'h0,         32'h0, 4'd10}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic wr, input logic [1:0] sz, input logic [15:0] a,
                       input logic [31:0] d, output logic [31:0] q);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = wr; bus_size = sz; bus_addr = a; bus_wdata = d;
        #1 q = bus_rdata;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sz, input logic [6:0] o, input logic [31:0] d);
        logic [31:0] q;
        bus(1'b1, sz, win | 16'(o), d, q);
    endtask

    task automatic rd(input logic [1:0] sz, input logic [6:0] o, output logic [31:0] q);
        bus(1'b0, sz, win | 16'(o), 32'h0, q);
    endtask

    task automatic set_base(input logic [15:0] b);
        @(negedge clk);
        cfg_base_we = 1'b1; cfg_base = b[15:7];
        @(negedge clk);
        cfg_base_we = 1'b0;
        if (b != 16'h0) win = b;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: pwrbtn_evt = 1'b1;
            1: rtc_evt = 1'b1;
            2: glk_evt = 1'b1;
            3: pwrdown_req = 1'b1;
            default: ;
        endcase
        @(negedge clk);
        pwrbtn_evt = 1'b0; rtc_evt = 1'b0; glk_evt = 1'b0; pwrdown_req = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] q, t1, t2;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        check("R11 sci after reset", 32'(sci), 32'h0);
        bus(1'b0, 2'd2, 16'h0000, 32'h0, q);
        check("R1 base zero read at 0", q, 32'h0);
        bus(1'b0, 2'd2, 16'h0430, 32'h0, q);
        check("R1 unmapped read", q, 32'h0);

        set_base(16'h0400);
        rd(2'd2, 7'h00, q); check("R11 status/enable cleared", q, 32'h0);
        rd(2'd2, 7'h30, q); check("R11 word enable cleared", q, 32'h0);
        rd(2'd2, 7'h28, q); check("R11 gpe enable cleared", q, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) wr(VECS[i].sz, VECS[i].off, VECS[i].wd);
            else begin
                rd(VECS[i].sz, VECS[i].off, q);
                check($sformatf("R%0d vector %0d", VECS[i].rq, i), q, VECS[i].ex);
            end
        end

        // R2 / R4 events (enable = 0x0520)
        pulse(0);
        rd(2'd1, 7'h00, q); check("R2 power button status", q, 32'h0100);
        check("R4 sci from power button", 32'(sci), 32'h1);
        wr(2'd1, 7'h00, 32'h0100);
        rd(2'd1, 7'h00, q); check("R2 write-one clear", q, 32'h0);
        check("R4 sci drops", 32'(sci), 32'h0);
        pulse(1); pulse(2);
        rd(2'd1, 7'h00, q); check("R2 alarm and lock bits", q, 32'h0420);
        wr(2'd1, 7'h00, 32'h0020);
        rd(2'd1, 7'h00, q); check("R2 partial clear", q, 32'h0400);
        wr(2'd1, 7'h00, 32'hFFFF);
        pulse(3);
        rd(2'd1, 7'h00, q); check("R2 power-down request", q, 32'h0100);
        wr(2'd1, 7'h00, 32'hFFFF);

        // R2 event in same cycle as clear
        @(negedge clk);
        pwrbtn_evt = 1'b1; bus_req = 1'b1; bus_wr = 1'b1; bus_size = 2'd1;
        bus_addr = win; bus_wdata = 32'h0100;
        @(negedge clk);
        pwrbtn_evt = 1'b0; bus_req = 1'b0; bus_wr = 1'b0;
        rd(2'd1, 7'h00, q); check("R2 set wins over clear", q, 32'h0100);

        // R4 masking by enable
        wr(2'd1, 7'h02, 32'h0000);
        check("R4 sci masked", 32'(sci), 32'h0);
        wr(2'd1, 7'h02, 32'h0100);
        check("R4 sci on enable", 32'(sci), 32'h1);
        wr(2'd1, 7'h00, 32'hFFFF);

        // R7 general-purpose events
        @(negedge clk); gpe_evt[3] = 1'b1; gpe_evt[60] = 1'b1;
        @(negedge clk); gpe_evt = '0;
        rd(2'd2, 7'h20, q); check("R7 gpe status low", q, 32'h0000_0008);
        rd(2'd2, 7'h24, q); check("R7 gpe status high", q, 32'h1000_0000);
        check("R4 gpe no sci", 32'(sci), 32'h0);
        wr(2'd0, 7'h20, 32'h08);
        wr(2'd0, 7'h27, 32'h10);
        rd(2'd2, 7'h20, q); check("R7 gpe clear low", q, 32'h0);
        rd(2'd2, 7'h24, q); check("R7 gpe clear high", q, 32'h0);

        // R5 timer
        rd(2'd2, 7'h08, t1);
        rd(2'd2, 7'h08, t2);
        check("R5 timer step", (t2 - t1) & TMASK, 32'd2);
        check("R5 timer width", t2 & ~TMASK, 32'h0);

        // R6 timer status arming
        repeat (1100) @(posedge clk);
        rd(2'd1, 7'h00, q); check("R6 not armed", q, 32'h0);
        wr(2'd1, 7'h02, 32'h0001);
        repeat (1100) @(posedge clk);
        rd(2'd1, 7'h00, q); check("R6 armed sets status", q, 32'h0001);
        check("R4 sci from timer", 32'(sci), 32'h1);
        wr(2'd1, 7'h02, 32'h0000);
        wr(2'd1, 7'h00, 32'hFFFF);

        // R1 relocation and unmapping
        wr(2'd1, 7'h02, 32'h0100);
        set_base(16'h0800);
        bus(1'b0, 2'd2, 16'h0430, 32'h0, q); check("R1 old window silent", q, 32'h0);
        rd(2'd2, 7'h30, q); check("R1 new window", q, 32'hDEAD_BEEF);
        set_base(16'h0000);
        bus(1'b1, 2'd1, 16'h0802, 32'hFFFF, q);
        bus(1'b0, 2'd1, 16'h0802, 32'h0, q); check("R1 unmapped read", q, 32'h0);
        set_base(16'h0800);
        rd(2'd1, 7'h02, q); check("R1 unmapped write ignored", q, 32'h0100);

        // R11 reset mid-run
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        bus(1'b0, 2'd2, 16'h0830, 32'h0, q); check("R11 base cleared", q, 32'h0);
        set_base(16'h0800);
        rd(2'd2, 7'h30, q); check("R11 word enable reset", q, 32'h0);
        rd(2'd2, 7'h04, q); check("R11 control reset", q, 32'h0);

        finish_run();
    end
endmodule